// File: doc/BRIEF.md
# Split Short/Long Lifetime Register Value Cache

This block holds a small number of recently produced register values in front of a slower 96-entry physical register file. The store has two parts. A 12-entry shift queue keeps values that are expected to be consumed shortly after writeback. A 16-entry, 4-way, 4-set array keeps values that are expected to stay in demand for longer. Each writeback carries the physical register number, the value and the producing instruction's PC. A one-bit lifetime guess, kept per PC in a small direct-mapped table, chooses which part receives the value.

The guess is trained from what happens to the value. A queue entry that is read only after it has aged past half the queue marks its PC as long-lived. An array entry that is evicted without ever being read marks its PC as short-lived. Both parts are searched in parallel on every read, and a hit returns its value in the same cycle. On a miss the block flags the miss and passes the backing file's value through. That value is not installed in the cache.

Top module: `split_reg_cache`

## Requirements
- R1: A writeback whose PC's lifetime bit is 0 (short) enters the queue; a bit of 1 (long) places it in the array, in set `tag[1:0]`.
- R2: The lifetime table has 64 one-bit entries indexed by `pc[7:2]`, and every entry resets to 0 (short).
- R3: A read of a cached tag raises `rd_hit` and returns the cached value in the same cycle; a read of an uncached tag raises `rd_miss`, drives `fill_data` on `rd_data`, and does not install the value.
- R4: A value written in one cycle is returned by a read of its tag in the next cycle; a read in the same cycle as the write returns the earlier contents.
- R5: At most one valid copy of a tag exists. A writeback removes any older copy from either part.
- R6: The queue drops its oldest slot on overflow. An entry still hits after 11 later queue insertions and misses after the 12th.
- R7: A queue read hit on an entry with 6 or more later queue insertions sets its producer's lifetime bit to 1. A hit with 5 or fewer leaves the bit unchanged.
- R8: Within a set, an empty way is filled first (lowest way number). Otherwise the least recently written or read way is replaced.
- R9: Replacing an array way that was never read since it was written clears its producer's lifetime bit to 0.
- R10: Reset empties both parts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | 7 | Physical register number written |
| wb_data | input | 32 | Value written |
| wb_pc | input | 32 | PC of the producing instruction |
| rd_valid | input | 1 | Read lookup strobe |
| rd_tag | input | 7 | Physical register number looked up |
| fill_data | input | 32 | Value from the backing register file for the looked-up tag |
| rd_hit | output | 1 | Lookup found the tag in the cache |
| rd_miss | output | 1 | Lookup did not find the tag |
| rd_data | output | 32 | Cached value on a hit, `fill_data` on a miss |

## Verification
On every cycle the assertions check four things. At most one part matches a lookup, and no part holds two matching entries. A miss passes the backing value through. A tag written in one cycle is visible with its new value in the next. The bench scenarios are needed to show where a value was placed and what the lifetime table learned, because this shows only at the ports. A value that survives twelve later short-lived writebacks must be in the array. The scenarios also cover the queue's drop point, the age boundary that trains a PC, LRU victim choice after a read refresh, and invalidation across the two parts.

// File: rtl/src_pkg.sv
// Shared sizing constants for the split register value cache.
package src_pkg;
    localparam int TAG_W      = 7;   // physical register number width (96 registers)
    localparam int DATA_W     = 32;  // register value width
    localparam int PC_W       = 32;  // instruction address width
    localparam int QDEPTH     = 12;  // short-lived queue slots
    localparam int SETS       = 4;   // long-lived array sets
    localparam int WAYS       = 4;   // long-lived array ways
    localparam int PIDX_W     = 6;   // lifetime table index width (64 entries)
    localparam int PC_SHIFT   = 2;   // PC bits dropped below the table index
endpackage

// File: rtl/src_life_table.sv
// Per-PC lifetime guess: one bit per entry, 1 means long-lived.
// Assumes the caller passes a pre-sliced PC index. Set beats clear on the
// same index in one cycle. Reset predicts short-lived everywhere.
module src_life_table #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_long,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] bits_q;

    // Combinational guess for the writeback in flight.
    assign look_long = bits_q[look_idx];

    // Training updates; the long mark is applied last so it wins a conflict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            if (clr_en) bits_q[clr_idx] <= 1'b0;
            if (set_en) bits_q[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/src_queue.sv
// Short-lived value queue: a shift register with the newest value at slot 0.
// Each push shifts every slot up by one; the top slot falls out. Slot number
// equals the count of later pushes. A push, or a bare invalidate, clears any
// older slot holding the same tag. Assumes at most one matching slot.
module src_queue #(
    parameter int DEPTH  = 12,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              inval,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              rd_aged,
    output logic [DEPTH-1:0]  rd_match
);
    localparam int POS_W = $clog2(DEPTH);
    localparam int HALF  = DEPTH / 2;

    logic [DEPTH-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DATA_W-1:0] dat_q  [DEPTH];
    logic [IDX_W-1:0]  pidx_q [DEPTH];
    logic [DEPTH-1:0]  wr_match;
    logic [POS_W-1:0]  rd_pos;

    // Parallel tag compare for the read and the write ports.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rd_match[i] = vld_q[i] && (tag_q[i] == rd_tag);
            wr_match[i] = vld_q[i] && (tag_q[i] == wr_tag);
        end
    end

    // Select the hitting slot and report whether it is in the older half.
    always_comb begin
        rd_pos = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (rd_match[i]) rd_pos = POS_W'(i);
        end
        hit     = |rd_match;
        rd_data = dat_q[rd_pos];
        rd_idx  = pidx_q[rd_pos];
        rd_aged = (32'(rd_pos) >= HALF);
    end

    // Shift on push, or drop the stale copy on a bare invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (push) begin
            vld_q[0]  <= 1'b1;
            tag_q[0]  <= wr_tag;
            dat_q[0]  <= wr_data;
            pidx_q[0] <= wr_idx;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i]  <= vld_q[i-1] && !wr_match[i-1];
                tag_q[i]  <= tag_q[i-1];
                dat_q[i]  <= dat_q[i-1];
                pidx_q[i] <= pidx_q[i-1];
            end
        end else if (inval) begin
            vld_q <= vld_q & ~wr_match;
        end
    end
endmodule

// File: rtl/src_assoc.sv
// Long-lived value array: SETS x WAYS, set chosen by the low tag bits.
// Replacement is LRU via per-way age ranks (0 = most recent). A read hit marks
// the way as used and refreshes it unless a write touches the same set that
// cycle. Replacing a never-read way reports its producer index for training.
module src_assoc #(
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              inval_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              rd_en,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data,
    output logic [WAYS-1:0]   rd_match,
    output logic              evict_en,
    output logic [IDX_W-1:0]  evict_idx
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [SETS-1:0][WAYS-1:0] vld_q, used_q;
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] dat_q  [SETS][WAYS];
    logic [IDX_W-1:0]  pidx_q [SETS][WAYS];
    logic [WAY_W-1:0]  age_q  [SETS][WAYS];

    logic [SET_W-1:0] rset, wset;
    logic [WAYS-1:0]  wr_match;
    logic [WAY_W-1:0] rd_way, hit_way, free_way, lru_way, tgt_way;
    logic             whit, free_found;

    assign rset = rd_tag[SET_W-1:0];
    assign wset = wr_tag[SET_W-1:0];

    // Read-side compare and way select.
    always_comb begin
        rd_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            rd_match[w] = vld_q[rset][w] && (tag_q[rset][w] == rd_tag);
            if (rd_match[w]) rd_way = WAY_W'(w);
        end
        hit     = |rd_match;
        rd_data = dat_q[rset][rd_way];
    end

    // Write-side way choice: existing copy, else lowest empty, else oldest.
    always_comb begin
        hit_way    = '0;
        free_way   = '0;
        lru_way    = '0;
        free_found = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            wr_match[w] = vld_q[wset][w] && (tag_q[wset][w] == wr_tag);
            if (wr_match[w]) hit_way = WAY_W'(w);
            if (!vld_q[wset][w]) begin
                free_way   = WAY_W'(w);
                free_found = 1'b1;
            end
            if (age_q[wset][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
        end
        whit      = |wr_match;
        tgt_way   = whit ? hit_way : (free_found ? free_way : lru_way);
        evict_en  = wr_en && !whit && !free_found && !used_q[wset][lru_way];
        evict_idx = pidx_q[wset][lru_way];
    end

    // Storage, use marks and LRU ranks; the write is applied after the read touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            used_q <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else begin
            if (rd_en && hit) begin
                used_q[rset][rd_way] <= 1'b1;
                if (!(wr_en && wset == rset)) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (WAY_W'(w) == rd_way)
                            age_q[rset][w] <= '0;
                        else if (age_q[rset][w] < age_q[rset][rd_way])
                            age_q[rset][w] <= age_q[rset][w] + 1'b1;
                    end
                end
            end
            if (wr_en) begin
                vld_q[wset][tgt_way]  <= 1'b1;
                used_q[wset][tgt_way] <= 1'b0;
                tag_q[wset][tgt_way]  <= wr_tag;
                dat_q[wset][tgt_way]  <= wr_data;
                pidx_q[wset][tgt_way] <= wr_idx;
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == tgt_way)
                        age_q[wset][w] <= '0;
                    else if (age_q[wset][w] < age_q[wset][tgt_way])
                        age_q[wset][w] <= age_q[wset][w] + 1'b1;
                end
            end else if (inval_en && whit) begin
                vld_q[wset][hit_way] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/split_reg_cache.sv
// Top of the split register value cache. Steers each writeback by the
// per-PC lifetime guess, searches both parts on a read, and trains the guess.
// Assumes one writeback and one read per cycle, and that fill_data is valid
// for rd_tag in the read cycle. Misses are not installed.
module split_reg_cache
    import src_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [PC_W-1:0]   wb_pc,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rd_hit,
    output logic              rd_miss,
    output logic [DATA_W-1:0] rd_data
);
    logic [PIDX_W-1:0] wb_idx;
    logic              pred_long;
    logic              q_hit, q_aged, a_hit, a_evict;
    logic [DATA_W-1:0] q_data, a_data;
    logic [PIDX_W-1:0] q_idx, a_evict_idx;
    logic [QDEPTH-1:0] q_match;
    logic [WAYS-1:0]   a_match;

    assign wb_idx = wb_pc[PC_SHIFT +: PIDX_W];

    src_life_table #(.IDX_W(PIDX_W)) u_life (
        .clk(clk), .rst_n(rst_n),
        .look_idx(wb_idx), .look_long(pred_long),
        .set_en(rd_valid && q_hit && q_aged), .set_idx(q_idx),
        .clr_en(a_evict), .clr_idx(a_evict_idx)
    );

    src_queue #(.DEPTH(QDEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(PIDX_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(wb_valid && !pred_long), .inval(wb_valid && pred_long),
        .wr_tag(wb_tag), .wr_data(wb_data), .wr_idx(wb_idx),
        .rd_tag(rd_tag), .hit(q_hit), .rd_data(q_data), .rd_idx(q_idx),
        .rd_aged(q_aged), .rd_match(q_match)
    );

    src_assoc #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(PIDX_W)) u_assoc (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wb_valid && pred_long), .inval_en(wb_valid && !pred_long),
        .wr_tag(wb_tag), .wr_data(wb_data), .wr_idx(wb_idx),
        .rd_en(rd_valid), .rd_tag(rd_tag), .hit(a_hit), .rd_data(a_data),
        .rd_match(a_match), .evict_en(a_evict), .evict_idx(a_evict_idx)
    );

    // Merge the two lookups; a miss passes the backing value through.
    always_comb begin
        rd_hit  = rd_valid && (q_hit || a_hit);
        rd_miss = rd_valid && !(q_hit || a_hit);
        if (q_hit)      rd_data = q_data;
        else if (a_hit) rd_data = a_data;
        else            rd_data = fill_data;
    end
endmodule

// File: rtl/split_reg_cache_chk.sv
// Property checker bound to split_reg_cache; observes ports and part-level hits.
module split_reg_cache_chk
    import src_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wb_valid,
    input logic [TAG_W-1:0]  wb_tag,
    input logic [DATA_W-1:0] wb_data,
    input logic              rd_valid,
    input logic [TAG_W-1:0]  rd_tag,
    input logic [DATA_W-1:0] fill_data,
    input logic              rd_hit,
    input logic              rd_miss,
    input logic [DATA_W-1:0] rd_data,
    input logic              q_hit,
    input logic              a_hit,
    input logic [QDEPTH-1:0] q_match,
    input logic [WAYS-1:0]   a_match
);
    AST_ONE_PART: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !(q_hit && a_hit)); // R5
    AST_QUEUE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_match)); // R5
    AST_SET_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(a_match)); // R5
    AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_miss |-> (!rd_hit && rd_data == fill_data)); // R3
    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wb_valid) && rd_valid && rd_tag == $past(wb_tag))
            |-> (rd_hit && rd_data == $past(wb_data))); // R4
endmodule

bind split_reg_cache split_reg_cache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wb_data(wb_data), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .fill_data(fill_data), .rd_hit(rd_hit), .rd_miss(rd_miss),
    .rd_data(rd_data), .q_hit(q_hit), .a_hit(a_hit),
    .q_match(q_match), .a_match(a_match)
);

// File: tb/split_reg_cache_bench.sv
// Self-checking bench: a vector table, then directed placement and training tests.
module split_reg_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wb_valid, rd_valid;
    logic [6:0]  wb_tag, rd_tag;
    logic [31:0] wb_data, wb_pc, fill_data, rd_data;
    logic        rd_hit, rd_miss;
    logic        o_hit, o_miss;
    logic [31:0] o_data;
    int total = 0;
    int bad   = 0;

    localparam logic [31:0] PC_S  = 32'h0000_0004; // index 1, stays short
    localparam logic [31:0] PC_L  = 32'h0000_00F0; // index 60, trained long
    localparam logic [31:0] PC_N  = 32'h0000_00E0; // index 56, read too young
    localparam logic [31:0] PC_OV = 32'h0000_0008; // index 2, overflow test

    always #5 clk = ~clk;

    assign fill_data = 32'hF000_0000 | {25'd0, rd_tag};

    split_reg_cache u_split_reg_cache (
        .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .wb_data(wb_data), .wb_pc(wb_pc), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .fill_data(fill_data), .rd_hit(rd_hit), .rd_miss(rd_miss), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        wv;
        logic [6:0]  wt;
        logic [31:0] wd;
        logic [31:0] wp;
        logic        rv;
        logic [6:0]  rt;
        logic        eh;
        logic [31:0] ed;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 7'd0, 32'h0,  32'h0,     1'b1, 7'd5, 1'b0, 32'hF000_0005},
        '{1'b1, 7'd5, 32'h55, 32'h100,   1'b1, 7'd5, 1'b0, 32'hF000_0005},
        '{1'b0, 7'd0, 32'h0,  32'h0,     1'b1, 7'd5, 1'b1, 32'h55},
        '{1'b1, 7'd5, 32'h66, 32'h104,   1'b1, 7'd5, 1'b1, 32'h55},
        '{1'b0, 7'd0, 32'h0,  32'h0,     1'b1, 7'd5, 1'b1, 32'h66},
        '{1'b1, 7'd9, 32'h99, 32'h108,   1'b1, 7'd9, 1'b0, 32'hF000_0009},
        '{1'b0, 7'd0, 32'h0,  32'h0,     1'b1, 7'd9, 1'b1, 32'h99}
    };

    // Compare one observed value against its expectation.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge and sample outputs shortly after.
    task automatic cyc(input logic wv, input logic [6:0] wt, input logic [31:0] wd,
                       input logic [31:0] wp, input logic rv, input logic [6:0] rt);
        @(negedge clk);
        wb_valid = wv; wb_tag = wt; wb_data = wd; wb_pc = wp;
        rd_valid = rv; rd_tag = rt;
        #1;
        o_hit = rd_hit; o_miss = rd_miss; o_data = rd_data;
    endtask

    task automatic wr(input logic [6:0] t, input logic [31:0] d, input logic [31:0] pc);
        cyc(1'b1, t, d, pc, 1'b0, 7'd0);
    endtask

    // Read a tag and check hit/miss flags and the returned value.
    task automatic rd_chk(input string req, input logic [6:0] t, input logic eh,
                          input logic [31:0] ed);
        cyc(1'b0, 7'd0, 32'd0, 32'd0, 1'b1, t);
        check({req, " hit"},  {31'd0, o_hit},  {31'd0, eh});
        check({req, " miss"}, {31'd0, o_miss}, {31'd0, !eh});
        check({req, " data"}, o_data, eh ? ed : (32'hF000_0000 | {25'd0, t}));
    endtask

    // Twelve short-lived writebacks: flushes every older queue slot.
    task automatic flush();
        for (int i = 0; i < 12; i++) wr(7'(64 + i), 32'(i), PC_S);
    endtask

    initial begin
        rst_n = 1'b0; wb_valid = 0; rd_valid = 0;
        wb_tag = 0; rd_tag = 0; wb_data = 0; wb_pc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd_chk("R10 empty after reset", 7'd5, 1'b0, 32'd0);

        // R3 R4: table of writes and same/next-cycle reads.
        for (int v = 0; v < 7; v++) begin
            cyc(VECS[v].wv, VECS[v].wt, VECS[v].wd, VECS[v].wp, VECS[v].rv, VECS[v].rt);
            check($sformatf("R3 R4 vec%0d hit", v), {31'd0, o_hit}, {31'd0, VECS[v].eh});
            check($sformatf("R3 R4 vec%0d data", v), o_data, VECS[v].ed);
        end
        rd_chk("R3 miss not installed", 7'd7, 1'b0, 32'd0);

        // R6: survives 11 later pushes, dropped by the 12th.
        wr(7'd40, 32'h40, PC_OV);
        for (int i = 0; i < 11; i++) wr(7'(64 + i), 32'(i), PC_S);
        rd_chk("R6 last slot", 7'd40, 1'b1, 32'h40);
        wr(7'd75, 32'd11, PC_S);
        rd_chk("R6 dropped", 7'd40, 1'b0, 32'd0);

        // R7 R1: aged read trains long; next value lands in the array.
        wr(7'd20, 32'h20, PC_L);
        for (int i = 0; i < 6; i++) wr(7'(64 + i), 32'(i), PC_S);
        rd_chk("R7 aged hit", 7'd20, 1'b1, 32'h20);
        wr(7'd30, 32'h30, PC_L);
        flush();
        rd_chk("R1 R7 long value kept", 7'd30, 1'b1, 32'h30);
        rd_chk("R6 aged entry dropped", 7'd20, 1'b0, 32'd0);

        // R7: a read at age 5 does not train.
        wr(7'd21, 32'h21, PC_N);
        for (int i = 0; i < 5; i++) wr(7'(64 + i), 32'(i), PC_S);
        rd_chk("R7 young hit", 7'd21, 1'b1, 32'h21);
        wr(7'd31, 32'h31, PC_N);
        flush();
        rd_chk("R7 young stays short", 7'd31, 1'b0, 32'd0);

        // R5: rewrites move a tag between parts without leaving a stale copy.
        wr(7'd33, 32'hA1, PC_S);
        wr(7'd33, 32'hB2, PC_L);
        rd_chk("R5 queue copy removed", 7'd33, 1'b1, 32'hB2);
        flush();
        rd_chk("R5 R1 array copy kept", 7'd33, 1'b1, 32'hB2);
        wr(7'd33, 32'hC3, PC_S);
        rd_chk("R5 newest value", 7'd33, 1'b1, 32'hC3);
        flush();
        rd_chk("R5 array copy removed", 7'd33, 1'b0, 32'd0);

        // R8 R9: set 0 fills ways 0..3, read refreshes tag 32, tag 36 is evicted unread.
        wr(7'd32, 32'h320, PC_L);
        wr(7'd36, 32'h360, PC_L);
        wr(7'd40, 32'h400, PC_L);
        wr(7'd44, 32'h440, PC_L);
        rd_chk("R8 refresh read", 7'd32, 1'b1, 32'h320);
        wr(7'd48, 32'h480, PC_L);
        rd_chk("R8 LRU victim", 7'd36, 1'b0, 32'd0);
        rd_chk("R8 refreshed kept", 7'd32, 1'b1, 32'h320);
        rd_chk("R8 other kept", 7'd40, 1'b1, 32'h400);
        rd_chk("R8 new way", 7'd48, 1'b1, 32'h480);
        wr(7'd52, 32'h520, PC_L);
        flush();
        rd_chk("R9 untrained to short", 7'd52, 1'b0, 32'd0);
        rd_chk("R9 array unaffected", 7'd44, 1'b1, 32'h440);

        // R10 R2: reset clears both parts and the lifetime table.
        @(negedge clk);
        rst_n = 1'b0; wb_valid = 0; rd_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R10 array cleared", 7'd30, 1'b0, 32'd0);
        rd_chk("R10 array cleared 2", 7'd44, 1'b0, 32'd0);
        wr(7'd20, 32'h20, PC_L);
        for (int i = 0; i < 6; i++) wr(7'(64 + i), 32'(i), PC_S);
        rd_chk("R2 aged hit again", 7'd20, 1'b1, 32'h20);
        wr(7'd34, 32'h34, 32'h0000_01F0); // pc[7:2] = 60, aliases PC_L
        flush();
        rd_chk("R2 aliased index shares bit", 7'd34, 1'b1, 32'h34);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wr(7'd35, 32'h35, PC_L);
        flush();
        rd_chk("R2 R10 table reset short", 7'd35, 1'b0, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule